// File: doc/BRIEF.md
# Multi-Commit Reorder Buffer

This block keeps instructions in program order while they finish out of order. A dispatch stage hands it up to four instructions per cycle. Each carries a tag and a destination register. The buffer stores them in a circular queue of slots. Execution units report finished tags on result-bus lanes. The buffer marks the matching slot as done.

The oldest instructions leave through commit ports, which free their register-map claims. Every done slot in an unbroken run from the head commits in one cycle, up to the number of ports. An instruction that reports done can commit at the earliest in the cycle after its result-bus cycle. A done instruction stays in the buffer while any older one is still pending.

Dispatch is throttled by a three-state occupancy machine:
- OCC_EMPTY: nothing is held.
- OCC_OPEN: entries are held and at least four slots are free.
- OCC_TIGHT: fewer than four slots are free.

Its transitions follow the occupancy each clock edge will leave behind:
- Every state goes to OCC_EMPTY when that occupancy is zero.
- Every state goes to OCC_TIGHT when fewer than four slots will be free.
- Every state goes to OCC_OPEN otherwise.
- A synchronous reset forces OCC_EMPTY.

The ready output is low only in OCC_TIGHT.

Top module: `rob_core`

## Requirements
- R1: After a synchronous reset, no commit port is valid and `alloc_ready` is high.
- R2: When `alloc_ready` is high, each lane with its bit set in `alloc_valid` takes the next free slot. Lanes are taken in increasing lane number, and lanes that are not set leave no gap. Program order therefore follows lane order, then cycle order.
- R3: A result-bus lane with its valid bit set marks the entry with the matching tag as done. That entry may commit at the earliest in the cycle after the result-bus cycle, never in the same cycle.
- R4: Commit happens strictly in program order: a done entry is not committed while any older entry is not done.
- R5: All done entries in an unbroken run from the oldest entry commit together. Port 0 always carries the oldest entry and the ports fill upward with no gaps. Each port outputs the entry's tag and destination register.
- R6: At most four entries commit per cycle, and the rest of a longer done run commits in the following cycles.
- R7: `alloc_ready` is low whenever fewer than four slots are free. While it is low, allocation requests are ignored.
- R8: A result-bus report in the same cycle that the matching tag is allocated marks that new entry done.
- R9: A result-bus tag that matches no held entry has no effect, even if that tag is allocated later.
- R10: The buffer holds all 16 entries, and its pointers wrap around the slot array without losing order.
- R11: Reset at any time discards all held entries and all done marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 4 | Per-lane allocation request |
| alloc_tag | input | 24 | Per-lane tag, lane i at bits [6i+5:6i] |
| alloc_dest | input | 20 | Per-lane destination register, lane i at bits [5i+4:5i] |
| alloc_ready | output | 1 | At least four slots free; allocation accepted |
| cmpl_valid | input | 2 | Result-bus lane valid |
| cmpl_tag | input | 12 | Result-bus tags, lane j at bits [6j+5:6j] |
| commit_valid | output | 4 | Commit port valid, port 0 oldest |
| commit_tag | output | 24 | Committed tags, port k at bits [6k+5:6k] |
| commit_dest | output | 20 | Committed destination registers, port k at bits [5k+4:5k] |

## Verification
The embedded assertions watch several properties every cycle:
- every allocation lands in an empty slot;
- the occupancy never exceeds the capacity;
- commits never outnumber the held entries;
- the tail pointer never moves while the machine is in OCC_TIGHT;
- reset empties the buffer.

Other behaviours depend on the values that flow through and can only be shown by the bench's directed scenarios:
- tag matching;
- the one-cycle distance from result to commit;
- holding a done entry behind a pending one;
- splitting a long done run across cycles;
- marking an entry done in the cycle it is allocated;
- dropping stray tags;
- wrap-around at full capacity.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_OPEN  = 2'd1,
        OCC_TIGHT = 2'd2
    } occ_state_e;

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
    parameter int ALLOC_W = 4,
    parameter int IDX_W   = 4,
    parameter int AN_W    = 3
) (
    input  logic               grant,
    input  logic [ALLOC_W-1:0] req,
    input  logic [IDX_W-1:0]   tail_idx,
    output logic [ALLOC_W-1:0] lane_we,
    output logic [IDX_W-1:0]   lane_slot [ALLOC_W],
    output logic [AN_W-1:0]    lane_n
);

    logic [AN_W-1:0] ofs;

    always_comb begin
        ofs = '0;
        for (int i = 0; i < ALLOC_W; i++) begin
            lane_we[i]   = grant && req[i];
            lane_slot[i] = tail_idx + IDX_W'(ofs);
            if (lane_we[i]) begin
                ofs = ofs + AN_W'(1);
            end
        end
        lane_n = ofs;
    end

endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
    parameter int DEPTH    = 16,
    parameter int ALLOC_W  = 4,
    parameter int COMMIT_W = 4,
    parameter int CMPL_W   = 2,
    parameter int TAG_W    = 6,
    parameter int REG_W    = 5,
    parameter int IDX_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ALLOC_W-1:0]        lane_we,
    input  logic [IDX_W-1:0]          lane_slot [ALLOC_W],
    input  logic [ALLOC_W*TAG_W-1:0]  lane_tag,
    input  logic [ALLOC_W*REG_W-1:0]  lane_dest,
    input  logic [CMPL_W-1:0]         res_valid,
    input  logic [CMPL_W*TAG_W-1:0]   res_tag,
    input  logic [COMMIT_W-1:0]       pop_valid,
    input  logic [IDX_W-1:0]          pop_slot [COMMIT_W],
    output logic [DEPTH-1:0]          ent_valid,
    output logic [DEPTH-1:0]          ent_done,
    output logic [TAG_W-1:0]          ent_tag  [DEPTH],
    output logic [REG_W-1:0]          ent_dest [DEPTH]
);

    function automatic logic tag_seen(input logic [TAG_W-1:0] t);
        logic hit;
        hit = 1'b0;
        for (int j = 0; j < CMPL_W; j++) begin
            if (res_valid[j] && (res_tag[j*TAG_W +: TAG_W] == t)) begin
                hit = 1'b1;
            end
        end
        return hit;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            ent_done  <= '0;
        end else begin
            for (int d = 0; d < DEPTH; d++) begin
                if (ent_valid[d] && tag_seen(ent_tag[d])) begin
                    ent_done[d] <= 1'b1;
                end
            end
            for (int c = 0; c < COMMIT_W; c++) begin
                if (pop_valid[c]) begin
                    ent_valid[pop_slot[c]] <= 1'b0;
                    ent_done[pop_slot[c]]  <= 1'b0;
                end
            end
            for (int i = 0; i < ALLOC_W; i++) begin
                if (lane_we[i]) begin
                    ent_valid[lane_slot[i]] <= 1'b1;
                    ent_done[lane_slot[i]]  <= tag_seen(lane_tag[i*TAG_W +: TAG_W]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ALLOC_W; i++) begin
            if (lane_we[i]) begin
                ent_tag[lane_slot[i]]  <= lane_tag[i*TAG_W +: TAG_W];
                ent_dest[lane_slot[i]] <= lane_dest[i*REG_W +: REG_W];
            end
        end
    end

    generate
        for (genvar g = 0; g < ALLOC_W; g++) begin : g_slot_chk
            assert_alloc_free_slot_R2: assert property (
                @(posedge clk) disable iff (rst)
                lane_we[g] |-> !ent_valid[lane_slot[g]]
            );
        end
    endgenerate

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
    parameter int DEPTH    = 16,
    parameter int COMMIT_W = 4,
    parameter int TAG_W    = 6,
    parameter int REG_W    = 5,
    parameter int IDX_W    = 4,
    parameter int CN_W     = 3
) (
    input  logic [IDX_W-1:0]          head_idx,
    input  logic [DEPTH-1:0]          ent_valid,
    input  logic [DEPTH-1:0]          ent_done,
    input  logic [TAG_W-1:0]          ent_tag  [DEPTH],
    input  logic [REG_W-1:0]          ent_dest [DEPTH],
    output logic [COMMIT_W-1:0]       port_valid,
    output logic [COMMIT_W*TAG_W-1:0] port_tag,
    output logic [COMMIT_W*REG_W-1:0] port_dest,
    output logic [IDX_W-1:0]          port_slot [COMMIT_W],
    output logic [CN_W-1:0]           port_n
);

    logic run;

    always_comb begin
        run    = 1'b1;
        port_n = '0;
        for (int c = 0; c < COMMIT_W; c++) begin
            port_slot[c]                 = head_idx + IDX_W'(c);
            port_valid[c]                = run && ent_valid[port_slot[c]] && ent_done[port_slot[c]];
            port_tag[c*TAG_W +: TAG_W]   = ent_tag[port_slot[c]];
            port_dest[c*REG_W +: REG_W]  = ent_dest[port_slot[c]];
            run                          = port_valid[c];
            port_n                       = port_n + CN_W'(port_valid[c]);
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ALLOC_W  = 4,
    parameter int COMMIT_W = 4,
    parameter int CMPL_W   = 2,
    parameter int TAG_W    = 6,
    parameter int REG_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ALLOC_W-1:0]        alloc_valid,
    input  logic [ALLOC_W*TAG_W-1:0]  alloc_tag,
    input  logic [ALLOC_W*REG_W-1:0]  alloc_dest,
    output logic                      alloc_ready,
    input  logic [CMPL_W-1:0]         cmpl_valid,
    input  logic [CMPL_W*TAG_W-1:0]   cmpl_tag,
    output logic [COMMIT_W-1:0]       commit_valid,
    output logic [COMMIT_W*TAG_W-1:0] commit_tag,
    output logic [COMMIT_W*REG_W-1:0] commit_dest
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;
    localparam int AN_W  = $clog2(ALLOC_W + 1);
    localparam int CN_W  = $clog2(COMMIT_W + 1);

    occ_state_e state_q, state_d;

    logic [PTR_W-1:0] head_q, tail_q, count_q, count_d;
    logic [ALLOC_W-1:0] lane_we;
    logic [IDX_W-1:0]   lane_slot [ALLOC_W];
    logic [AN_W-1:0]    alloc_n;
    logic [COMMIT_W-1:0] pop_valid;
    logic [IDX_W-1:0]    pop_slot [COMMIT_W];
    logic [CN_W-1:0]     commit_n;
    logic [DEPTH-1:0]    ent_valid, ent_done;
    logic [TAG_W-1:0]    ent_tag  [DEPTH];
    logic [REG_W-1:0]    ent_dest [DEPTH];

    assign count_q = tail_q - head_q;
    assign count_d = count_q - PTR_W'(commit_n) + PTR_W'(alloc_n);

    rob_alloc #(.ALLOC_W(ALLOC_W), .IDX_W(IDX_W), .AN_W(AN_W)) u_alloc (
        .grant     (alloc_ready),
        .req       (alloc_valid),
        .tail_idx  (tail_q[IDX_W-1:0]),
        .lane_we   (lane_we),
        .lane_slot (lane_slot),
        .lane_n    (alloc_n)
    );

    rob_entries #(
        .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .COMMIT_W(COMMIT_W), .CMPL_W(CMPL_W),
        .TAG_W(TAG_W), .REG_W(REG_W), .IDX_W(IDX_W)
    ) u_entries (
        .clk       (clk),
        .rst       (rst),
        .lane_we   (lane_we),
        .lane_slot (lane_slot),
        .lane_tag  (alloc_tag),
        .lane_dest (alloc_dest),
        .res_valid (cmpl_valid),
        .res_tag   (cmpl_tag),
        .pop_valid (pop_valid),
        .pop_slot  (pop_slot),
        .ent_valid (ent_valid),
        .ent_done  (ent_done),
        .ent_tag   (ent_tag),
        .ent_dest  (ent_dest)
    );

    rob_retire #(
        .DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .TAG_W(TAG_W), .REG_W(REG_W),
        .IDX_W(IDX_W), .CN_W(CN_W)
    ) u_retire (
        .head_idx   (head_q[IDX_W-1:0]),
        .ent_valid  (ent_valid),
        .ent_done   (ent_done),
        .ent_tag    (ent_tag),
        .ent_dest   (ent_dest),
        .port_valid (pop_valid),
        .port_tag   (commit_tag),
        .port_dest  (commit_dest),
        .port_slot  (pop_slot),
        .port_n     (commit_n)
    );

    assign commit_valid = pop_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(commit_n);
            tail_q <= tail_q + PTR_W'(alloc_n);
        end
    end

    always_comb begin
        if (count_d == '0) begin
            state_d = OCC_EMPTY;
        end else if (count_d > PTR_W'(DEPTH - ALLOC_W)) begin
            state_d = OCC_TIGHT;
        end else begin
            state_d = OCC_OPEN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            OCC_EMPTY: alloc_ready = 1'b1;
            OCC_OPEN:  alloc_ready = 1'b1;
            OCC_TIGHT: alloc_ready = 1'b0;
            default:   alloc_ready = 1'b0;
        endcase
    end

    assert_reset_empty_R1: assert property (
        @(posedge clk) rst |=> (commit_valid == '0) && (state_q == OCC_EMPTY)
    );

    assert_no_overflow_R7: assert property (
        @(posedge clk) disable iff (rst) count_q <= PTR_W'(DEPTH)
    );

    assert_tight_holds_tail_R7: assert property (
        @(posedge clk) disable iff (rst) (state_q == OCC_TIGHT) |=> tail_q == $past(tail_q)
    );

    assert_commit_within_occ_R6: assert property (
        @(posedge clk) disable iff (rst) PTR_W'(commit_n) <= count_q
    );

endmodule

// File: tb/test_rob_core.sv
module test_rob_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  alloc_valid = '0;
    logic [23:0] alloc_tag = '0;
    logic [19:0] alloc_dest = '0;
    logic        alloc_ready;
    logic [1:0]  cmpl_valid = '0;
    logic [11:0] cmpl_tag = '0;
    logic [3:0]  commit_valid;
    logic [23:0] commit_tag;
    logic [19:0] commit_dest;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rob_core i_rob_core (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .commit_valid(commit_valid), .commit_tag(commit_tag), .commit_dest(commit_dest)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_alloc(input logic [3:0] v, input int t0, input int t1, input int t2, input int t3);
        alloc_valid = v;
        alloc_tag   = {6'(t3), 6'(t2), 6'(t1), 6'(t0)};
        alloc_dest  = {5'(t3), 5'(t2), 5'(t1), 5'(t0)};
    endtask

    task automatic set_cmpl(input logic [1:0] v, input int t0, input int t1);
        cmpl_valid = v;
        cmpl_tag   = {6'(t1), 6'(t0)};
    endtask

    task automatic idle();
        set_alloc(4'b0000, 0, 0, 0, 0);
        set_cmpl(2'b00, 0, 0);
    endtask

    task automatic chk_commit(input string req, input logic [3:0] ev,
                              input int t0, input int t1, input int t2, input int t3);
        int et[4];
        et = '{t0, t1, t2, t3};
        chk({req, " commit_valid"}, int'(commit_valid), int'(ev));
        for (int k = 0; k < 4; k++) begin
            if (ev[k]) begin
                chk({req, " tag"}, int'(commit_tag[k*6 +: 6]), et[k] % 64);
                chk({req, " dest"}, int'(commit_dest[k*5 +: 5]), et[k] % 32);
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; idle();
        cyc(); cyc();
        rst = 1'b0;
        chk_commit("R1", 4'b0000, 0, 0, 0, 0);
        chk("R1 ready", int'(alloc_ready), 1);
    endtask

    task automatic t_order_hold();
        set_alloc(4'b0111, 1, 2, 3, 0); cyc(); idle();
        set_cmpl(2'b11, 1, 3);
        chk_commit("R3 same cycle", 4'b0000, 0, 0, 0, 0);
        cyc(); idle();
        chk_commit("R3", 4'b0001, 1, 0, 0, 0);
        cyc();
        chk_commit("R4 held", 4'b0000, 0, 0, 0, 0);
        set_cmpl(2'b01, 2, 0); cyc(); idle();
        chk_commit("R5 pair", 4'b0011, 2, 3, 0, 0);
        cyc();
        chk_commit("R5 drained", 4'b0000, 0, 0, 0, 0);
    endtask

    task automatic t_sparse_lanes();
        set_alloc(4'b1010, 0, 50, 0, 51); cyc(); idle();
        set_cmpl(2'b11, 51, 50); cyc(); idle();
        chk_commit("R2 packed", 4'b0011, 50, 51, 0, 0);
        cyc();
    endtask

    task automatic t_same_cycle();
        set_alloc(4'b1111, 10, 11, 12, 13);
        set_cmpl(2'b11, 10, 12);
        cyc(); idle();
        chk_commit("R8", 4'b0001, 10, 0, 0, 0);
        cyc();
        chk_commit("R8 held", 4'b0000, 0, 0, 0, 0);
        set_cmpl(2'b11, 11, 13); cyc(); idle();
        chk_commit("R8 run", 4'b0111, 11, 12, 13, 0);
        cyc();
    endtask

    task automatic t_port_limit();
        set_alloc(4'b1111, 20, 21, 22, 23); cyc();
        set_alloc(4'b0011, 24, 25, 0, 0); cyc(); idle();
        set_cmpl(2'b11, 21, 22); cyc();
        set_cmpl(2'b11, 23, 24); cyc();
        set_cmpl(2'b01, 25, 0); cyc(); idle();
        chk_commit("R4 head pending", 4'b0000, 0, 0, 0, 0);
        set_cmpl(2'b01, 20, 0); cyc(); idle();
        chk_commit("R6 four", 4'b1111, 20, 21, 22, 23);
        cyc();
        chk_commit("R6 rest", 4'b0011, 24, 25, 0, 0);
        cyc();
        chk_commit("R6 empty", 4'b0000, 0, 0, 0, 0);
    endtask

    task automatic t_stray_tag();
        set_alloc(4'b0001, 40, 0, 0, 0); cyc(); idle();
        set_cmpl(2'b01, 41, 0); cyc(); idle();
        set_alloc(4'b0001, 41, 0, 0, 0); cyc(); idle();
        cyc();
        chk_commit("R9 none", 4'b0000, 0, 0, 0, 0);
        set_cmpl(2'b01, 40, 0); cyc(); idle();
        chk_commit("R9 stray ignored", 4'b0001, 40, 0, 0, 0);
        set_cmpl(2'b01, 41, 0); cyc(); idle();
        chk_commit("R9 real", 4'b0001, 41, 0, 0, 0);
        cyc();
    endtask

    task automatic t_fill_wrap();
        for (int b = 0; b < 4; b++) begin
            chk("R7 ready before fill", int'(alloc_ready), 1);
            set_alloc(4'b1111, 32 + 4*b, 33 + 4*b, 34 + 4*b, 35 + 4*b);
            cyc();
        end
        idle();
        chk("R7 ready low", int'(alloc_ready), 0);
        set_alloc(4'b1111, 60, 61, 62, 63); cyc(); idle();
        set_cmpl(2'b11, 60, 61); cyc();
        for (int p = 7; p >= 0; p--) begin
            set_cmpl(2'b11, 33 + 2*p, 32 + 2*p);
            cyc();
            if (p == 4) chk_commit("R10 waiting", 4'b0000, 0, 0, 0, 0);
        end
        idle();
        for (int b = 0; b < 4; b++) begin
            chk_commit("R10 wrap", 4'b1111, 32 + 4*b, 33 + 4*b, 34 + 4*b, 35 + 4*b);
            cyc();
            chk("R7 ready back", int'(alloc_ready), 1);
        end
        chk_commit("R7 ignored alloc", 4'b0000, 0, 0, 0, 0);
        cyc();
        chk_commit("R7 ignored alloc later", 4'b0000, 0, 0, 0, 0);
    endtask

    task automatic t_mid_reset();
        set_alloc(4'b0111, 1, 2, 3, 0); cyc(); idle();
        set_cmpl(2'b11, 1, 2);
        rst = 1'b1; cyc(); rst = 1'b0; idle();
        chk_commit("R11 cleared", 4'b0000, 0, 0, 0, 0);
        chk("R11 ready", int'(alloc_ready), 1);
        set_cmpl(2'b01, 3, 0); cyc(); idle();
        chk_commit("R11 no stale", 4'b0000, 0, 0, 0, 0);
        set_alloc(4'b0001, 5, 0, 0, 0); cyc(); idle();
        set_cmpl(2'b01, 5, 0); cyc(); idle();
        chk_commit("R11 reuse", 4'b0001, 5, 0, 0, 0);
        cyc();
    endtask

    initial begin
        t_reset();
        t_order_hold();
        t_sparse_lanes();
        t_same_cycle();
        t_port_limit();
        t_stray_tag();
        t_fill_wrap();
        t_mid_reset();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule